// File: doc/BRIEF.md
# Hierarchical State-Enable CSR Unit

This block keeps the access-gating registers that a RISC-V hart with the hypervisor extension uses to control which optional architectural state less-privileged code may touch. It holds three registers. The machine-level enable register is 64 bits wide. The hypervisor-level enable register is 64 bits wide and gates guest modes. The supervisor-level enable register is 32 bits wide. Each bit enables one class of extension state. A level gates only the modes below it and never its own.

The surrounding pipeline presents CSR accesses on a single-cycle port. Each access carries an address, an operation, write data, the current privilege and the virtualization flag. Read data and the fault verdict come back combinationally in the same cycle. The register update commits on the next rising clock edge, and only when the access does not fault. The pipeline can also ask whether an access to one extension's state is allowed in the current mode. The block answers with an illegal-instruction or virtual-instruction fault. It also exports per-extension permit vectors for the two guest modes.

A write to the hypervisor register is masked bit by bit by the machine register. The view of the supervisor register seen from the guest supervisor mode is forced to zero wherever the hypervisor register is zero.

Top module: `se_csr_unit`

## Requirements
- R1: After a synchronous active-low reset, all three registers read as zero, and every permit output is zero.
- R2: The machine register is at CSR address 0x30C, the hypervisor register at 0x60C and the supervisor register at 0x10C. The operation codes are 0 = read, 1 = write, 2 = set bits and 3 = clear bits. An access to any other address returns zero read data, raises no fault and changes no register.
- R3: In the machine and hypervisor registers, only bits 0, 1, 2, 54, 57, 58, 59, 60, 62 and 63 hold a value. In the supervisor register, only bits 0, 1 and 2 hold a value. Every other bit reads as zero.
- R4: A write to the hypervisor register stores zero in every bit whose machine-register bit is zero at the time of the write.
- R5: Set and clear operations form the read-modify-write value first. They then apply the same masking as a plain write.
- R6: The machine register is accessible only in M mode; any other mode raises an illegal-instruction fault. For the hypervisor register, VS and VU modes raise a virtual-instruction fault and U mode raises an illegal-instruction fault. HS mode raises an illegal-instruction fault when machine bit 63 is zero.
- R7: For the supervisor register, U mode raises an illegal-instruction fault and VU mode raises a virtual-instruction fault. HS and VS modes raise an illegal-instruction fault when machine bit 63 is zero. VS mode additionally raises a virtual-instruction fault when hypervisor bit 63 is zero.
- R8: In VS mode, a supervisor-register bit whose hypervisor bit is zero reads as zero. A write from VS mode leaves that bit unchanged, as seen from M mode afterwards.
- R9: In every mode, a supervisor-register bit whose machine bit is zero reads as zero and cannot be written.
- R10: A faulting CSR access returns zero read data and changes no register.
- R11: Extension index i = 0..9 maps to register bit 0, 1, 2, 54, 57, 58, 59, 60, 62 and 63 respectively. vs_permit[i] is the AND of the machine and hypervisor bits. vu_permit[i] additionally requires the supervisor bit for indices 0 to 2.
- R12: A state-access check on extension index i behaves as follows. M mode never faults. HS and U modes fault illegal when the machine bit is zero, and U mode also faults illegal when the supervisor bit (indices 0 to 2) is zero. VS and VU modes fault illegal when the machine bit is zero. Otherwise they fault virtual when the hypervisor bit is zero, and VU mode also faults virtual when the supervisor bit (indices 0 to 2) is zero. Indices 10 to 15 never fault. The privilege encoding is 3 = M, 1 = S, 0 or 2 = U, and the virtualization flag selects the guest form of S and U.
- R13: fault_illegal and fault_virtual are never high together. When a CSR access and a state check in the same cycle would raise different faults, the illegal-instruction fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | A CSR access is presented this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 64 | Write data or set/clear mask |
| priv | input | 2 | Current privilege: 3 M, 1 S, 0/2 U |
| virt | input | 1 | Hart is running a guest |
| st_valid | input | 1 | A state-access check is presented |
| st_ext | input | 4 | Extension index to check |
| csr_rdata | output | 64 | Read data, zero on fault or miss |
| vs_permit | output | 10 | Per-extension permits for VS mode |
| vu_permit | output | 10 | Per-extension permits for VU mode |
| fault_illegal | output | 1 | Illegal-instruction fault |
| fault_virtual | output | 1 | Virtual-instruction fault |

## Verification
A wrong register bit inside the unit becomes visible in the same cycle through the permit vectors. It also shows in the verdict of the next state-access check that names that extension, one cycle after the faulty update commits. A masking error on a hypervisor or supervisor write shows in the very next read of that register from M mode. A wrong VS-mode view shows when the guest reads the supervisor register. The reference model in the bench predicts the read data, both fault lines and both permit vectors before every edge. It does this for directed corner sequences and for a long stream of mixed accesses. Because of this, a corrupted bit cannot stay hidden for more than a few accesses.

// File: rtl/se_pkg.sv
// Shared types and constants for the state-enable CSR unit.
// Assumes a 64-bit hart; the supervisor register is 32 bits wide.
package se_pkg;
    localparam int XLEN    = 64;
    localparam int SLEN    = 32;
    localparam int NEXT    = 10;
    localparam int SE0_BIT = 63;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        MD_U, MD_VU, MD_HS, MD_VS, MD_M
    } mode_e;

    // Register bit that gates extension index i (ascending bit order).
    function automatic int ext_pos(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 54;
            4: return 57;
            5: return 58;
            6: return 59;
            7: return 60;
            8: return 62;
            default: return 63;
        endcase
    endfunction

    // Mask of implemented bits, built from the extension map.
    function automatic logic [XLEN-1:0] impl_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < NEXT; i++) m[ext_pos(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] IMPL_MASK = impl_mask();

    // Effective mode from privilege encoding and virtualization flag.
    function automatic mode_e to_mode(input logic [1:0] priv, input logic virt);
        if (priv == 2'd3) return MD_M;
        if (priv == 2'd1) return virt ? MD_VS : MD_HS;
        return virt ? MD_VU : MD_U;
    endfunction

    // Read-modify-write value for a CSR operation.
    function automatic logic [XLEN-1:0] rmw(input csr_op_e op,
                                             input logic [XLEN-1:0] old,
                                             input logic [XLEN-1:0] wd);
        case (op)
            OP_WRITE: return wd;
            OP_SET:   return old | wd;
            OP_CLEAR: return old & ~wd;
            default:  return old;
        endcase
    endfunction
endpackage

// File: rtl/se_access_ctl.sv
// CSR address decode and privilege check for the three enable registers.
// Assumes the caller zeroes read data and blocks the commit on any fault.
module se_access_ctl
    import se_pkg::*;
#(
    parameter logic [11:0] ADDR_M = 12'h30C,
    parameter logic [11:0] ADDR_H = 12'h60C,
    parameter logic [11:0] ADDR_S = 12'h10C
) (
    input  logic        csr_valid,
    input  logic [11:0] csr_addr,
    input  mode_e       mode,
    input  logic        m_se0,
    input  logic        h_se0,
    output logic        hit_m,
    output logic        hit_h,
    output logic        hit_s,
    output logic        csr_ill,
    output logic        csr_virt
);
    // Address hits for the three registers.
    always_comb begin
        hit_m = csr_valid && (csr_addr == ADDR_M);
        hit_h = csr_valid && (csr_addr == ADDR_H);
        hit_s = csr_valid && (csr_addr == ADDR_S);
    end

    // Fault classification per register and mode (R6, R7).
    always_comb begin
        csr_ill  = 1'b0;
        csr_virt = 1'b0;
        if (hit_m && mode != MD_M) csr_ill = 1'b1;
        if (hit_h) begin
            case (mode)
                MD_U:         csr_ill  = 1'b1;
                MD_VU, MD_VS: csr_virt = 1'b1;
                MD_HS:        csr_ill  = !m_se0;
                default:      ;
            endcase
        end
        if (hit_s) begin
            case (mode)
                MD_U:    csr_ill  = 1'b1;
                MD_VU:   csr_virt = 1'b1;
                MD_HS:   csr_ill  = !m_se0;
                MD_VS: begin
                    csr_ill  = !m_se0;
                    csr_virt = m_se0 && !h_se0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/se_state_regs.sv
// Storage for the machine, hypervisor and supervisor enable registers,
// with write masking and the mode-dependent supervisor read view.
// Assumes commit is asserted only for a non-faulting write-type access.
module se_state_regs
    import se_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            hit_m,
    input  logic            hit_h,
    input  logic            hit_s,
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic            is_vs,
    output logic [XLEN-1:0] mreg,
    output logic [XLEN-1:0] hreg,
    output logic [SLEN-1:0] sreg,
    output logic [XLEN-1:0] rd_val
);
    localparam logic [SLEN-1:0] S_IMPL = IMPL_MASK[SLEN-1:0];

    logic [SLEN-1:0] s_gate;
    logic [SLEN-1:0] s_view;
    logic [XLEN-1:0] s_rmw;
    logic [XLEN-1:0] m_next;
    logic [XLEN-1:0] h_next;
    logic [SLEN-1:0] s_next;

    // Supervisor bits visible in this mode (R8, R9).
    always_comb begin
        s_gate = mreg[SLEN-1:0] & (is_vs ? hreg[SLEN-1:0] : '1);
        s_view = sreg & s_gate;
    end

    // Read multiplexer over the addressed register.
    always_comb begin
        rd_val = '0;
        if (hit_m)      rd_val = mreg;
        else if (hit_h) rd_val = hreg;
        else if (hit_s) rd_val = {{(XLEN-SLEN){1'b0}}, s_view};
    end

    // Next values with implementation and hierarchy masking (R3, R4, R5).
    always_comb begin
        m_next = rmw(op, mreg, wdata) & IMPL_MASK;
        h_next = rmw(op, hreg, wdata) & IMPL_MASK & mreg;
        s_rmw  = rmw(op, {{(XLEN-SLEN){1'b0}}, s_view}, wdata);
        s_next = (s_rmw[SLEN-1:0] & S_IMPL & s_gate) | (sreg & ~(S_IMPL & s_gate));
    end

    // Register update on a committed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreg <= '0;
            hreg <= '0;
            sreg <= '0;
        end else if (commit) begin
            if (hit_m) mreg <= m_next;
            if (hit_h) hreg <= h_next;
            if (hit_s) sreg <= s_next;
        end
    end

    // R4: a committed hypervisor write never sets a bit the machine register lacked.
    a_r4_hyp_within_mach: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && hit_h) |=> ((hreg & ~$past(mreg)) == '0));

    // R8: a VS-mode write leaves bits hidden by the hypervisor register untouched.
    a_r8_vs_hidden_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && hit_s && is_vs) |=>
        (((sreg ^ $past(sreg)) & ~$past(hreg[SLEN-1:0])) == '0));
endmodule

// File: rtl/se_permit.sv
// Per-extension permit vectors for the guest modes and the state-access check.
// Assumes extension indices at or above NEXT are not gated by this unit.
module se_permit
    import se_pkg::*;
#(
    parameter int EXT_IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [XLEN-1:0]   mreg,
    input  logic [XLEN-1:0]   hreg,
    input  logic [SLEN-1:0]   sreg,
    input  logic              st_valid,
    input  logic [EXT_IW-1:0] st_ext,
    output logic [NEXT-1:0]   vs_permit,
    output logic [NEXT-1:0]   vu_permit,
    output logic              st_ill,
    output logic              st_virt
);
    logic [NEXT-1:0] m_bit;
    logic [NEXT-1:0] h_bit;
    logic [NEXT-1:0] s_bit;

    // Gather each extension's enable bits from the three levels (R11).
    for (genvar i = 0; i < NEXT; i++) begin : g_ext
        localparam int P = ext_pos(i);
        assign m_bit[i] = mreg[P];
        assign h_bit[i] = hreg[P];
        if (P < SLEN) begin : g_lo
            assign s_bit[i] = sreg[P];
        end else begin : g_hi
            assign s_bit[i] = 1'b1;
        end
        assign vs_permit[i] = m_bit[i] & h_bit[i];
        assign vu_permit[i] = m_bit[i] & h_bit[i] & s_bit[i];
    end

    // State-access verdict for the selected extension in the current mode (R12).
    always_comb begin
        logic hit, mb, hb, sb;
        hit = 1'b0; mb = 1'b0; hb = 1'b0; sb = 1'b0;
        for (int i = 0; i < NEXT; i++) begin
            if (st_ext == EXT_IW'(i)) begin
                hit = 1'b1;
                mb  = m_bit[i];
                hb  = h_bit[i];
                sb  = s_bit[i];
            end
        end
        st_ill  = 1'b0;
        st_virt = 1'b0;
        if (st_valid && hit) begin
            case (mode)
                MD_HS: st_ill = !mb;
                MD_U:  st_ill = !mb || !sb;
                MD_VS: begin
                    st_ill  = !mb;
                    st_virt = mb && !hb;
                end
                MD_VU: begin
                    st_ill  = !mb;
                    st_virt = mb && (!hb || !sb);
                end
                default: ;
            endcase
        end
    end

    // R12: machine mode is never gated by this unit.
    a_r12_m_never_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && mode == MD_M) |-> (!st_ill && !st_virt));
endmodule

// File: rtl/se_csr_unit.sv
// Top of the hierarchical state-enable CSR unit: decodes CSR accesses,
// holds the three enable registers and answers state-access checks.
// Assumes one access per cycle; read data and faults are combinational.
module se_csr_unit
    import se_pkg::*;
#(
    parameter logic [11:0] ADDR_M = 12'h30C,
    parameter logic [11:0] ADDR_H = 12'h60C,
    parameter logic [11:0] ADDR_S = 12'h10C,
    parameter int          EXT_IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic [11:0]       csr_addr,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              st_valid,
    input  logic [EXT_IW-1:0] st_ext,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [NEXT-1:0]   vs_permit,
    output logic [NEXT-1:0]   vu_permit,
    output logic              fault_illegal,
    output logic              fault_virtual
);
    mode_e           mode;
    csr_op_e         op;
    logic            hit_m, hit_h, hit_s;
    logic            csr_ill, csr_virt, st_ill, st_virt;
    logic            commit;
    logic [XLEN-1:0] mreg, hreg, rd_val;
    logic [SLEN-1:0] sreg;

    assign mode = to_mode(priv, virt);
    assign op   = csr_op_e'(csr_op);

    se_access_ctl #(.ADDR_M(ADDR_M), .ADDR_H(ADDR_H), .ADDR_S(ADDR_S)) u_access (
        .csr_valid (csr_valid),
        .csr_addr  (csr_addr),
        .mode      (mode),
        .m_se0     (mreg[SE0_BIT]),
        .h_se0     (hreg[SE0_BIT]),
        .hit_m     (hit_m),
        .hit_h     (hit_h),
        .hit_s     (hit_s),
        .csr_ill   (csr_ill),
        .csr_virt  (csr_virt)
    );

    // Commit only a non-faulting write-type access to a known register (R10).
    assign commit = (hit_m || hit_h || hit_s) && !csr_ill && !csr_virt && (op != OP_READ);

    se_state_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .hit_m  (hit_m),
        .hit_h  (hit_h),
        .hit_s  (hit_s),
        .op     (op),
        .wdata  (csr_wdata),
        .is_vs  (mode == MD_VS),
        .mreg   (mreg),
        .hreg   (hreg),
        .sreg   (sreg),
        .rd_val (rd_val)
    );

    se_permit #(.EXT_IW(EXT_IW)) u_permit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .mreg      (mreg),
        .hreg      (hreg),
        .sreg      (sreg),
        .st_valid  (st_valid),
        .st_ext    (st_ext),
        .vs_permit (vs_permit),
        .vu_permit (vu_permit),
        .st_ill    (st_ill),
        .st_virt   (st_virt)
    );

    // Output merge: read data hidden on fault, illegal wins over virtual (R13).
    always_comb begin
        csr_rdata     = (csr_ill || csr_virt) ? '0 : rd_val;
        fault_illegal = csr_ill || st_ill;
        fault_virtual = (csr_virt || st_virt) && !fault_illegal;
    end

    // R13: the two fault kinds are exclusive.
    a_r13_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_illegal, fault_virtual}));

    // R10: a faulting CSR access leaves all registers unchanged.
    a_r10_fault_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && (csr_ill || csr_virt)) |=>
        ($stable(mreg) && $stable(hreg) && $stable(sreg)));
endmodule

// File: tb/se_csr_unit_bench.sv
// Self-checking bench with a behavioural reference model of the three registers.
module se_csr_unit_bench;
    localparam logic [11:0] AM = 12'h30C;
    localparam logic [11:0] AH = 12'h60C;
    localparam logic [11:0] AS = 12'h10C;
    localparam logic [63:0] IMPL = 64'hDE40_0000_0000_0007;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, ST = 2'd2, CL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_valid;
    logic [11:0] csr_addr;
    logic [1:0]  csr_op;
    logic [63:0] csr_wdata;
    logic [1:0]  priv;
    logic        virt;
    logic        st_valid;
    logic [3:0]  st_ext;
    logic [63:0] csr_rdata;
    logic [9:0]  vs_permit, vu_permit;
    logic        fault_illegal, fault_virtual;

    always #4 clk = ~clk;

    se_csr_unit u_se_csr_unit (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .priv(priv), .virt(virt),
        .st_valid(st_valid), .st_ext(st_ext), .csr_rdata(csr_rdata),
        .vs_permit(vs_permit), .vu_permit(vu_permit),
        .fault_illegal(fault_illegal), .fault_virtual(fault_virtual)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int pos_t[10] = '{0, 1, 2, 54, 57, 58, 59, 60, 62, 63};

    // Model state.
    logic [63:0] mm, mh;
    logic [31:0] ms;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] f_rmw(logic [1:0] op, logic [63:0] o, logic [63:0] w);
        if (op == WR) return w;
        if (op == ST) return o | w;
        if (op == CL) return o & ~w;
        return o;
    endfunction

    // One access: drive after the falling edge, compare, then advance the model.
    task automatic step(string tag, logic cv, logic [11:0] a, logic [1:0] op,
                        logic [63:0] wd, logic [1:0] pv, logic vt,
                        logic sv, logic [3:0] se);
        bit is_m, hs, vs, u, vu, ci, cvf, si, svf, ei, ev, lo;
        logic [63:0] rd, nm, nh, sview, sgate, smask, r;
        logic [31:0] ns;
        logic [9:0] evs, evu;
        @(negedge clk);
        csr_valid = cv; csr_addr = a; csr_op = op; csr_wdata = wd;
        priv = pv; virt = vt; st_valid = sv; st_ext = se;
        #1;
        is_m = (pv == 2'd3);
        hs = (pv == 2'd1) && !vt;
        vs = (pv == 2'd1) && vt;
        vu = !is_m && (pv != 2'd1) && vt;
        u  = !is_m && (pv != 2'd1) && !vt;
        sgate = {32'h0, mm[31:0]};
        if (vs) sgate = sgate & {32'h0, mh[31:0]};
        sview = {32'h0, ms} & sgate;
        ci = 0; cvf = 0; rd = '0;
        if (cv && a == AM) begin
            if (!is_m) ci = 1; else rd = mm;
        end else if (cv && a == AH) begin
            if (vs || vu) cvf = 1;
            else if (u) ci = 1;
            else if (hs && !mm[63]) ci = 1;
            else rd = mh;
        end else if (cv && a == AS) begin
            if (u) ci = 1;
            else if (vu) cvf = 1;
            else if ((hs || vs) && !mm[63]) ci = 1;
            else if (vs && !mh[63]) cvf = 1;
            else rd = sview;
        end
        si = 0; svf = 0;
        if (sv && se < 10) begin
            int p;
            bit mb, hb, sb;
            p = pos_t[se];
            mb = mm[p]; hb = mh[p];
            sb = (p < 32) ? ms[p] : 1'b1;
            if (hs) si = !mb;
            if (u) si = !mb || !sb;
            if (vs) begin si = !mb; svf = mb && !hb; end
            if (vu) begin si = !mb; svf = mb && (!hb || !sb); end
        end
        ei = ci || si;
        ev = (cvf || svf) && !ei;
        for (int i = 0; i < 10; i++) begin
            evs[i] = mm[pos_t[i]] && mh[pos_t[i]];
            lo = pos_t[i] < 32;
            evu[i] = evs[i] && (lo ? ms[pos_t[i]] : 1'b1);
        end
        chk(tag, "rdata", csr_rdata, rd);
        chk(tag, "faults", {62'h0, fault_illegal, fault_virtual}, {62'h0, ei, ev});
        chk(tag, "vs_permit", {54'h0, vs_permit}, {54'h0, evs});
        chk(tag, "vu_permit", {54'h0, vu_permit}, {54'h0, evu});
        nm = mm; nh = mh; ns = ms;
        if (cv && !ci && !cvf && op != RD) begin
            if (a == AM) nm = f_rmw(op, mm, wd) & IMPL;
            if (a == AH) nh = f_rmw(op, mh, wd) & IMPL & mm;
            if (a == AS) begin
                r = f_rmw(op, sview, wd);
                smask = sgate & 64'h7;
                ns = (r[31:0] & smask[31:0]) | (ms & ~smask[31:0]);
            end
        end
        @(posedge clk);
        mm = nm; mh = nh; ms = ns;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; csr_valid = 0; csr_addr = '0; csr_op = '0; csr_wdata = '0;
        priv = 2'd3; virt = 0; st_valid = 0; st_ext = '0;
        mm = '0; mh = '0; ms = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        step("R1", 1, AM, RD, 0, 3, 0, 0, 0);
        step("R1", 1, AH, RD, 0, 3, 0, 0, 0);
        step("R1", 1, AS, RD, 0, 3, 0, 0, 0);
        // R3 implemented bits
        step("R3", 1, AM, WR, '1, 3, 0, 0, 0);
        step("R3", 1, AM, RD, 0, 3, 0, 0, 0);
        step("R3", 1, AH, WR, '1, 1, 0, 0, 0);
        step("R3", 1, AH, RD, 0, 3, 0, 0, 0);
        step("R3", 1, AS, WR, '1, 1, 0, 0, 0);
        step("R11", 1, AS, RD, 0, 1, 1, 0, 0);
        // R4 / R5 hierarchy masking
        step("R5", 1, AM, CL, 64'h2, 3, 0, 0, 0);
        step("R4", 1, AH, WR, 0, 1, 0, 0, 0);
        step("R4", 1, AH, ST, '1, 1, 0, 0, 0);
        step("R4", 1, AH, RD, 0, 1, 0, 0, 0);
        step("R5", 1, AH, CL, 64'h1, 1, 0, 0, 0);
        // R8 / R9 supervisor views
        step("R8", 1, AS, RD, 0, 1, 1, 0, 0);
        step("R8", 1, AS, WR, 0, 1, 1, 0, 0);
        step("R9", 1, AS, RD, 0, 3, 0, 0, 0);
        step("R9", 1, AS, ST, '1, 1, 0, 0, 0);
        step("R9", 1, AS, RD, 0, 1, 0, 0, 0);
        // R6 / R7 privilege faults
        step("R6", 1, AM, RD, 0, 1, 0, 0, 0);
        step("R6", 1, AH, RD, 0, 1, 1, 0, 0);
        step("R6", 1, AH, RD, 0, 0, 1, 0, 0);
        step("R6", 1, AH, RD, 0, 0, 0, 0, 0);
        step("R7", 1, AS, RD, 0, 0, 0, 0, 0);
        step("R7", 1, AS, RD, 0, 0, 1, 0, 0);
        // R10 faulting write changes nothing
        step("R10", 1, AH, WR, 0, 0, 1, 0, 0);
        step("R10", 1, AM, WR, 0, 1, 0, 0, 0);
        step("R10", 1, AH, RD, 0, 3, 0, 0, 0);
        // R7 SE0 gating
        step("R7", 1, AH, CL, 64'h8000_0000_0000_0000, 1, 0, 0, 0);
        step("R7", 1, AS, RD, 0, 1, 1, 0, 0);
        step("R6", 1, AM, CL, 64'h8000_0000_0000_0000, 3, 0, 0, 0);
        step("R6", 1, AH, RD, 0, 1, 0, 0, 0);
        step("R7", 1, AS, RD, 0, 1, 0, 0, 0);
        step("R7", 1, AS, RD, 0, 1, 1, 0, 0);
        // R2 foreign address
        step("R2", 1, 12'h123, WR, '1, 3, 0, 0, 0);
        step("R2", 1, AM, RD, 0, 3, 0, 0, 0);
        // R13 CSR virtual plus state illegal
        step("R13", 1, AH, RD, 0, 1, 1, 1, 4'd1);
        // R12 state checks over every mode and index
        for (int pv = 0; pv < 4; pv++)
            for (int vt = 0; vt < 2; vt++)
                for (int e = 0; e < 16; e++)
                    step("R12", 0, 0, RD, 0, pv[1:0], vt[0], 1, e[3:0]);
        // R11 mixed stream against the model
        for (int k = 0; k < 1500; k++) begin
            logic [11:0] a;
            logic [63:0] w;
            int sel;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? AM : (sel == 1) ? AH : (sel == 2) ? AS : 12'h7C0;
            w = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) w = '1;
            step("R11", $urandom_range(0, 4) != 0, a, 2'($urandom_range(0, 3)), w,
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule